// File: doc/BRIEF.md
# Dual-Direction Storing Bus Transceiver

This block moves an 18-bit word between two ports, A and B, in both directions at once. Each direction has its own storage element, its own sampled capture clock, its own latch-open control and its own output enable. While the latch-open control is high, the element is transparent and the far port shows the near port's data in the same cycle. While it is low, the element holds its contents. It loads new data only when its capture clock is seen going from low to high.

The block sits in a synchronous design. The two capture clocks and the two latch-open inputs are treated as data and sampled on the system clock `clk`. Each port returns a data vector and a drive flag, never an inout net, so the surrounding logic or a pad wrapper turns the pair into tri-state drive. Drive strength, skew and power-off behaviour are outside this model.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `rst_n` is low, both drive flags are 0 whatever the enables are. Both storage elements clear to zero, so after release with the latches closed and no capture, both data outputs read zero.
- R2: While `ab_open` is 1, `b_out` equals `a_in` in the same cycle. This holds even if `ab_clk` rises.
- R3: While `ab_open` is 0 and `ab_clk` shows no low-to-high change, `b_out` keeps its value, whatever `a_in` does.
- R4: When `ab_open` is 0 and `ab_clk` is sampled 1 at a `clk` edge after being sampled 0 at the previous edge, the element stores the `a_in` sampled at that edge, and `b_out` shows it from then on.
- R5: A high-to-low change of `ab_clk` while `ab_open` is 0 leaves the stored value unchanged.
- R6: When `ab_open` falls with no capture, the element keeps the `a_in` sampled at the last `clk` edge at which `ab_open` was 1.
- R7: If `ab_open` is first sampled 0 at the same `clk` edge where `ab_clk` is first sampled 1, the element captures the `a_in` of that edge.
- R8: Outside reset, `b_oe` follows `ab_oe` (active high) and `a_oe` is the inverse of `ba_oe_n` (active low). Neither flag changes the data outputs.
- R9: The B-to-A path obeys R2 to R7 with `b_in`, `ba_open`, `ba_clk` and `a_out`. It is unaffected by any A-to-B control, and the A-to-B path is unaffected by any B-to-A control.
- R10: A direction whose drive flag is 0 still loads and tracks data, and the loaded value appears once the flag returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every control |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | WIDTH | Data arriving at port A |
| a_out | output | WIDTH | Data presented to port A by the B-to-A path |
| a_oe | output | 1 | Drive flag for port A |
| b_in | input | WIDTH | Data arriving at port B |
| b_out | output | WIDTH | Data presented to port B by the A-to-B path |
| b_oe | output | 1 | Drive flag for port B |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_open | input | 1 | A-to-B latch-open control |
| ab_clk | input | 1 | A-to-B capture clock, sampled |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_open | input | 1 | B-to-A latch-open control |
| ba_clk | input | 1 | B-to-A capture clock, sampled |

## Verification
A latch closing and a capture clock rising can land on the same `clk` edge. At that edge the capture must win, so the element takes the data of that edge and not the value it held while open. The bench forces this coincidence on purpose in one directed step, and random control toggling hits it again in both directions. A bench-side reference, built from the requirements, says which value must appear, and the outputs are compared after the edge.

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             ab_oe,
  input  logic             ab_open,
  input  logic             ab_clk,
  input  logic             ba_oe_n,
  input  logic             ba_open,
  input  logic             ba_clk
);

  logic [WIDTH-1:0] hold_ab, hold_ba;
  logic             ab_clk_q, ba_clk_q;
  logic             ab_rise, ba_rise;

  assign ab_rise = ab_clk & ~ab_clk_q;
  assign ba_rise = ba_clk & ~ba_clk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_ab  <= '0;
      ab_clk_q <= 1'b0;
    end else begin
      ab_clk_q <= ab_clk;
      if (ab_open || ab_rise)
        hold_ab <= a_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_ba  <= '0;
      ba_clk_q <= 1'b0;
    end else begin
      ba_clk_q <= ba_clk;
      if (ba_open || ba_rise)
        hold_ba <= b_in;
    end
  end

  assign b_out = ab_open ? a_in : hold_ab;
  assign a_out = ba_open ? b_in : hold_ba;
  assign b_oe  = rst_n & ab_oe;
  assign a_oe  = rst_n & ~ba_oe_n;

endmodule

// File: rtl/xcvr_props.sv
module xcvr_props #(
  parameter int WIDTH = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe,
  input logic             ab_oe,
  input logic             ab_open,
  input logic             ab_clk,
  input logic             ba_oe_n,
  input logic             ba_open,
  input logic             ba_clk
);

  always_comb begin
    if (!rst_n) AST_RST_QUIET: assert (!a_oe && !b_oe); // R1
  end

  AST_AB_TRANSP: assert property (@(posedge clk) disable iff (!rst_n) ab_open |-> b_out == a_in); // R2
  AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!ab_open && !$rose(ab_clk)) |=> (ab_open || $rose(ab_clk) || $stable(b_out))); // R3
  AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) (!ab_open && $rose(ab_clk)) |=> (ab_open || $rose(ab_clk) || b_out == $past(a_in))); // R4
  AST_AB_CLOSE: assert property (@(posedge clk) disable iff (!rst_n) ab_open |=> (ab_open || $rose(ab_clk) || b_out == $past(a_in))); // R6
  AST_BA_TRANSP: assert property (@(posedge clk) disable iff (!rst_n) ba_open |-> a_out == b_in); // R9
  AST_BA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) (!ba_open && $rose(ba_clk)) |=> (ba_open || $rose(ba_clk) || a_out == $past(b_in))); // R9
  AST_BA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!ba_open && !$rose(ba_clk)) |=> (ba_open || $rose(ba_clk) || $stable(a_out))); // R9
  AST_OE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n) (b_oe == ab_oe) && (a_oe != ba_oe_n)); // R8

endmodule

bind bus_xcvr_reg xcvr_props #(.WIDTH(WIDTH)) u_props (.*);

// File: tb/sim_bus_xcvr_reg.sv
`timescale 1ns/1ps
module sim_bus_xcvr_reg;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;
  logic ab_oe = 1'b1, ab_open = 1'b0, ab_clk = 1'b0;
  logic ba_oe_n = 1'b0, ba_open = 1'b0, ba_clk = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bus_xcvr_reg #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_oe(ab_oe), .ab_open(ab_open), .ab_clk(ab_clk),
    .ba_oe_n(ba_oe_n), .ba_open(ba_open), .ba_clk(ba_clk)
  );

  // reference state, built from the requirement text
  logic [W-1:0] m_ab, m_ba;
  logic p_ab, p_ba;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ab <= '0; m_ba <= '0; p_ab <= 1'b0; p_ba <= 1'b0;
    end else begin
      if (ab_open) m_ab <= a_in;
      else if (ab_clk && !p_ab) m_ab <= a_in;
      if (ba_open) m_ba <= b_in;
      else if (ba_clk && !p_ba) m_ba <= b_in;
      p_ab <= ab_clk;
      p_ba <= ba_clk;
    end
  end

  function automatic logic [W-1:0] pick(input logic open, input logic [W-1:0] din, input logic [W-1:0] st);
    return open ? din : st;
  endfunction

  task automatic cmp(input string tag, input string what, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    #2;
    cmp(tag, "b_out", b_out, pick(ab_open, a_in, m_ab));
    cmp(tag, "a_out", a_out, pick(ba_open, b_in, m_ba));
    cmp(tag, "b_oe", {17'd0, b_oe}, {17'd0, rst_n & ab_oe});
    cmp(tag, "a_oe", {17'd0, a_oe}, {17'd0, rst_n & ~ba_oe_n});
  endtask

  function automatic logic [W-1:0] rnd();
    return W'($urandom);
  endfunction

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    a_in = rnd(); b_in = rnd();
    tick("R1"); tick("R1");
    rst_n = 1'b1;
    tick("R1");
    cmp("R1", "b_out zero", b_out, '0);
    cmp("R1", "a_out zero", a_out, '0);

    ab_open = 1'b1; a_in = 18'h2A5A5;
    tick("R2");
    cmp("R2", "b_out follow", b_out, 18'h2A5A5);
    a_in = 18'h13C3C; ab_clk = 1'b1;
    tick("R2");
    ab_clk = 1'b0;
    tick("R2");

    ab_open = 1'b0; a_in = 18'h00FF0;
    tick("R6");
    cmp("R6", "b_out closed", b_out, 18'h13C3C);

    a_in = 18'h3FFFF; tick("R3");
    a_in = 18'h01234; tick("R3");
    cmp("R3", "b_out held", b_out, 18'h13C3C);

    a_in = 18'h0BEEF; ab_clk = 1'b1; tick("R4");
    cmp("R4", "b_out captured", b_out, 18'h0BEEF);
    a_in = 18'h11111; tick("R4");

    ab_clk = 1'b0; a_in = 18'h22222; tick("R5");
    cmp("R5", "b_out after fall", b_out, 18'h0BEEF);

    ab_open = 1'b1; a_in = 18'h33333; tick("R7");
    ab_open = 1'b0; ab_clk = 1'b1; a_in = 18'h05AC3; tick("R7");
    cmp("R7", "b_out coincident", b_out, 18'h05AC3);
    ab_clk = 1'b0; tick("R7");

    ab_oe = 1'b0; ba_oe_n = 1'b1; tick("R8");
    cmp("R8", "b_out unaffected", b_out, 18'h05AC3);
    ab_clk = 1'b1; a_in = 18'h2D2D2; tick("R10");
    ab_clk = 1'b0; ab_oe = 1'b1; tick("R10");
    cmp("R10", "b_out after reenable", b_out, 18'h2D2D2);
    ba_clk = 1'b1; b_in = 18'h1E1E1; tick("R10");
    ba_clk = 1'b0; ba_oe_n = 1'b0; tick("R10");
    cmp("R10", "a_out after reenable", a_out, 18'h1E1E1);

    ba_open = 1'b1; b_in = 18'h30303; tick("R9");
    cmp("R9", "a_out follow", a_out, 18'h30303);
    ba_open = 1'b0; ba_clk = 1'b1; b_in = 18'h0C0C0; ab_open = 1'b1; a_in = 18'h3A3A3; tick("R9");
    cmp("R9", "a_out coincident", a_out, 18'h0C0C0);
    ba_clk = 1'b0; b_in = 18'h01010; tick("R9");
    cmp("R9", "a_out held", a_out, 18'h0C0C0);
    ab_open = 1'b0;

    for (int i = 0; i < 3000; i++) begin
      a_in = rnd(); b_in = rnd();
      ab_open = ($urandom_range(0, 3) == 0);
      ba_open = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 1) == 1) ab_clk = ~ab_clk;
      if ($urandom_range(0, 1) == 1) ba_clk = ~ba_clk;
      ab_oe = $urandom_range(0, 1) == 1;
      ba_oe_n = $urandom_range(0, 1) == 1;
      tick("R9");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule